// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This block sits beside a pulse counter and decides when that counter should be wiped. On each trigger it compares the counter's present value against a TOP value. If the comparison holds, it issues a one-cycle clear strobe and raises a sticky match flag. The trigger comes from one of two sources. The first is a prescaled tick of the sampling clock, divided by 1, 2, 4 or 8. The second is an edge of an external trigger line, taken after a two-stage synchronizer.

The same external line can also stall the counter. When gating is switched on, the count-gate output drops while the synchronized line sits at its active level. The active level is high when polarity is clear and low when polarity is set. Gating is configured apart from triggering, so the line can gate, trigger, or do both.

There are three compare modes. Two are plain threshold tests. The third is a window test: the upper half of TOP is the inclusive upper bound and the lower half is the inclusive lower bound. The counter itself and any register interface are outside this block.

Top module: `tcc_unit`

## Requirements
- R1: After reset `clearStrobe` and `matchFlag` are 0, and `countGate` is 1 while `gateEn` is 0.
- R2: With `trigMode` 0 or 3 (disabled) no clear strobe is ever produced, whatever `trigIn`, `count` and `top` do.
- R3: With `trigMode` 1 (tick), `prescSel` value p gives a trigger every 2^p cycles. The first trigger falls in the 2^p-th cycle spent in tick mode (counting from 1), and later ones follow every 2^p cycles.
- R4: The prescaler restarts from zero whenever `trigMode` leaves 1, so re-entering tick mode restarts the R3 spacing.
- R5: With `cmpMode` 0 a trigger matches when `count <= top` (unsigned).
- R6: With `cmpMode` 1 a trigger matches when `count >= top` (unsigned).
- R7: With `cmpMode` 2 a trigger matches when `count >= top[7:0]` and `count <= top[15:8]`, both bounds inclusive. With `cmpMode` 3 nothing matches.
- R8: With `trigMode` 2 (edge), `trigIn` passes through two synchronizer flops. A rising edge triggers when `trigPol` is 0, and a falling edge triggers when `trigPol` is 1.
- R9: A trigger that matches drives `clearStrobe` high for exactly the cycle after the trigger is sampled, and a trigger that does not match leaves it low.
- R10: `matchFlag` is set by every matching trigger and holds until a cycle with `flagClr` high. If a set and a clear fall in the same cycle, the set wins.
- R11: `countGate` is 0 exactly while `gateEn` is 1 and the synchronized `trigIn` equals the inverse of `trigPol`. This holds in every `trigMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigMode | input | 2 | 0 off, 1 prescaled tick, 2 trigger-line edge, 3 off |
| prescSel | input | 2 | Tick divider select: divide by 2^prescSel |
| cmpMode | input | 2 | 0 less-or-equal, 1 greater-or-equal, 2 window, 3 never |
| trigPol | input | 1 | 0: rising edge triggers, gate while high; 1: falling edge, gate while low |
| gateEn | input | 1 | Allow the trigger line to gate counting |
| trigIn | input | 1 | Asynchronous external trigger line |
| count | input | 16 | Present counter value |
| top | input | 16 | Compare value; window bounds in its two halves |
| flagClr | input | 1 | Clears the match flag |
| clearStrobe | output | 1 | One-cycle request to clear the counter |
| matchFlag | output | 1 | Sticky compare-match flag |
| countGate | output | 1 | 1 lets the counter advance |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- a strobe always has a trigger one cycle before it and always comes with the flag;
- the flag only falls after a clear request;
- no strobe appears in the off mode;
- the prescaler is zero after any cycle outside tick mode;
- a window-mode strobe always had its count inside the window;
- the gate stays open whenever gating is off.

Only the bench's scenarios show the exact tick spacing for each divider and the restart of that spacing on mode re-entry. They likewise show the two-flop latency of edge triggers for each polarity, and the inclusive boundaries of all three compare modes. Those scenarios are compared cycle by cycle against a behavioural model.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam logic [1:0] TRIG_OFF  = 2'd0;
  localparam logic [1:0] TRIG_TICK = 2'd1;
  localparam logic [1:0] TRIG_EDGE = 2'd2;

  localparam logic [1:0] CMP_LE    = 2'd0;
  localparam logic [1:0] CMP_GE    = 2'd1;
  localparam logic [1:0] CMP_RANGE = 2'd2;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic fire;     // a compare is requested this cycle
    logic gateOff;  // counting must pause this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/tcc_ctrl.sv
module tcc_ctrl
  import tcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             trigMode,
  input  logic [PRESC_SEL_W-1:0] prescSel,
  input  logic                   trigPol,
  input  logic                   gateEn,
  input  logic                   trigIn,
  output ctlStrobe_t             ctl
);
  localparam int PRESC_W = (2 ** PRESC_SEL_W) - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   syncd;
  logic [PRESC_W-1:0]     pcQ;
  logic [PRESC_W-1:0]     tickMask;
  logic                   tick;
  logic                   edgeSeen;
  logic                   tickMode;

  assign syncd    = syncQ[SYNC_STAGES-1];
  assign tickMode = (trigMode == TRIG_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], trigIn};
      prevQ <= syncd;
    end
  end

  // free-running divider, held at zero outside tick mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pcQ <= '0;
    else if (tickMode) pcQ <= pcQ + 1'b1;
    else               pcQ <= '0;
  end

  always_comb begin
    tickMask = PRESC_W'((32'd1 << prescSel) - 32'd1);
    tick     = ((pcQ & tickMask) == tickMask);
    edgeSeen = trigPol ? (prevQ & ~syncd) : (~prevQ & syncd);
    ctl.fire    = (tickMode & tick) | ((trigMode == TRIG_EDGE) & edgeSeen);
    ctl.gateOff = gateEn & (syncd ^ trigPol);
  end

  // R4
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickMode |=> (pcQ == '0));

  // R8
  edge_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == TRIG_EDGE && ctl.fire) |-> (syncd != $past(syncd)));
endmodule

// File: rtl/tcc_datapath.sv
module tcc_datapath
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [1:0]       cmpMode,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] top,
  input  logic             flagClr,
  output logic             clearStrobe,
  output logic             matchFlag
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] winHi;
  logic [CNT_W-1:0] winLo;
  logic             hit;
  logic             doClear;

  assign winHi = CNT_W'(top[CNT_W-1:HALF]);
  assign winLo = CNT_W'(top[HALF-1:0]);

  always_comb begin
    unique case (cmpMode)
      CMP_LE:    hit = (count <= top);
      CMP_GE:    hit = (count >= top);
      CMP_RANGE: hit = (count >= winLo) && (count <= winHi);
      default:   hit = 1'b0;
    endcase
    doClear = ctl.fire & hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearStrobe <= 1'b0;
      matchFlag   <= 1'b0;
    end else begin
      clearStrobe <= doClear;
      matchFlag   <= doClear | (matchFlag & ~flagClr);
    end
  end

  // R10
  strobe_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearStrobe |-> matchFlag);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(matchFlag) && !$past(flagClr)) |-> matchFlag);

  // R9
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearStrobe |-> $past(ctl.fire));

  // R7
  range_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearStrobe && $past(cmpMode) == CMP_RANGE) |->
      ($past(count) >= $past(winLo) && $past(count) <= $past(winHi)));
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             trigMode,
  input  logic [PRESC_SEL_W-1:0] prescSel,
  input  logic [1:0]             cmpMode,
  input  logic                   trigPol,
  input  logic                   gateEn,
  input  logic                   trigIn,
  input  logic [CNT_W-1:0]       count,
  input  logic [CNT_W-1:0]       top,
  input  logic                   flagClr,
  output logic                   clearStrobe,
  output logic                   matchFlag,
  output logic                   countGate
);
  ctlStrobe_t ctl;

  tcc_ctrl #(.SYNC_STAGES(SYNC_STAGES), .PRESC_SEL_W(PRESC_SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigMode(trigMode), .prescSel(prescSel),
    .trigPol(trigPol), .gateEn(gateEn), .trigIn(trigIn), .ctl(ctl)
  );

  tcc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmpMode(cmpMode), .count(count),
    .top(top), .flagClr(flagClr), .clearStrobe(clearStrobe), .matchFlag(matchFlag)
  );

  assign countGate = ~ctl.gateOff;

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(trigMode) == TRIG_OFF) |-> !clearStrobe);

  // R11
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |-> countGate);
endmodule

// File: tb/tcc_unit_tb.sv
`timescale 1ns/1ps
module tcc_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  trigMode = 2'd0;
  logic [1:0]  prescSel = 2'd0;
  logic [1:0]  cmpMode = 2'd0;
  logic        trigPol = 1'b0;
  logic        gateEn = 1'b0;
  logic        trigIn = 1'b0;
  logic [15:0] count = 16'd0;
  logic [15:0] top = 16'd0;
  logic        flagClr = 1'b0;
  logic        clearStrobe, matchFlag, countGate;

  int    checks = 0;
  int    failures = 0;
  bit    chkOn = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;  // 250 MHz

  tcc_unit u_dut (
    .clk(clk), .rstN(rstN), .trigMode(trigMode), .prescSel(prescSel),
    .cmpMode(cmpMode), .trigPol(trigPol), .gateEn(gateEn), .trigIn(trigIn),
    .count(count), .top(top), .flagClr(flagClr), .clearStrobe(clearStrobe),
    .matchFlag(matchFlag), .countGate(countGate)
  );

  // behavioural reference
  int m_s1, m_s2, m_prev, m_pc, m_str, m_flag;
  int divN, isTick, isEdge, isTrig, isHit;

  function automatic int matchOf(int cm, int c, int t);
    case (cm)
      0: return (c <= t) ? 1 : 0;
      1: return (c >= t) ? 1 : 0;
      2: return (c >= (t % 256) && c <= (t / 256)) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pc = 0; m_str = 0; m_flag = 0;
    end else begin
      divN   = 1 << prescSel;
      isTick = ((m_pc % divN) == divN - 1) ? 1 : 0;
      isEdge = trigPol ? ((m_prev == 1 && m_s2 == 0) ? 1 : 0)
                       : ((m_prev == 0 && m_s2 == 1) ? 1 : 0);
      isTrig = ((trigMode == 2'd1 && isTick == 1) || (trigMode == 2'd2 && isEdge == 1)) ? 1 : 0;
      isHit  = matchOf(int'(cmpMode), int'(count), int'(top));
      m_str  = isTrig & isHit;
      m_flag = (m_str == 1 || (m_flag == 1 && !flagClr)) ? 1 : 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(trigIn);
      m_pc   = (trigMode == 2'd1) ? (m_pc + 1) % 8 : 0;
    end
  end

  task automatic expectBit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      expectBit(curReq, "clearStrobe", clearStrobe, m_str[0]);
      expectBit(curReq, "matchFlag", matchFlag, m_flag[0]);
      expectBit(curReq, "countGate", countGate, !(gateEn && ((m_s2[0]) ^ trigPol)));
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state with hard expectations
    expectBit("R1", "clearStrobe", clearStrobe, 1'b0);
    expectBit("R1", "matchFlag", matchFlag, 1'b0);
    expectBit("R1", "countGate", countGate, 1'b1);
    #1;
    chkOn = 1'b1;

    // R2: disabled modes never strobe
    curReq = "R2";
    top = 16'hFFFF; count = 16'd0;
    for (int k = 0; k < 12; k++) begin trigIn = ~trigIn; cyc(3); end
    trigMode = 2'd3;
    for (int k = 0; k < 8; k++) begin trigIn = ~trigIn; cyc(3); end
    trigMode = 2'd0; trigIn = 1'b0; cyc(4);

    // R3 / R9: tick spacing for every divider, always matching
    curReq = "R3";
    for (int p = 0; p < 4; p++) begin
      prescSel = 2'(p); trigMode = 2'd1; cyc(20);
      flagClr = 1'b1; cyc(1); flagClr = 1'b0;
      trigMode = 2'd0; cyc(2);
    end
    curReq = "R9";
    trigMode = 2'd1; prescSel = 2'd2; cyc(9);
    top = 16'd0; count = 16'd5; cyc(8);
    trigMode = 2'd0; cyc(2);

    // R4: prescaler restart on leaving tick mode
    curReq = "R4";
    top = 16'hFFFF; count = 16'd0; prescSel = 2'd3;
    trigMode = 2'd1; cyc(5); trigMode = 2'd0; cyc(1);
    trigMode = 2'd1; cyc(12); trigMode = 2'd2; cyc(1);
    trigMode = 2'd1; cyc(10); prescSel = 2'd1; cyc(6);
    trigMode = 2'd0; cyc(2);

    // R5 R6 R7: compare boundaries, tick every cycle
    trigMode = 2'd1; prescSel = 2'd0;
    for (int cm = 0; cm < 4; cm++) begin
      cmpMode = 2'(cm);
      curReq = (cm == 0) ? "R5" : (cm == 1) ? "R6" : "R7";
      for (int ti = 0; ti < 4; ti++) begin
        top = (ti == 0) ? 16'h2010 : (ti == 1) ? 16'h1020 : (ti == 2) ? 16'h0000 : 16'hFFFF;
        for (int ci = 0; ci < 11; ci++) begin
          count = (ci == 0) ? 16'h0000 : (ci == 1) ? 16'h000F : (ci == 2) ? 16'h0010 :
                  (ci == 3) ? 16'h0011 : (ci == 4) ? 16'h001F : (ci == 5) ? 16'h0020 :
                  (ci == 6) ? 16'h0021 : (ci == 7) ? 16'h101F : (ci == 8) ? 16'h1020 :
                  (ci == 9) ? 16'h1021 : 16'hFFFF;
          flagClr = ci[0];
          cyc(1);
        end
      end
    end
    flagClr = 1'b0; trigMode = 2'd0; cmpMode = 2'd0; cyc(2);

    // R8: edge triggers for each polarity and pulse width
    curReq = "R8";
    top = 16'hFFFF; count = 16'd3; trigMode = 2'd2;
    for (int pol = 0; pol < 2; pol++) begin
      trigPol = pol[0]; trigIn = pol[0]; cyc(4);
      for (int w = 1; w < 6; w += 2) begin
        trigIn = ~trigIn; cyc(w); trigIn = ~trigIn; cyc(5);
      end
      flagClr = 1'b1; cyc(1); flagClr = 1'b0;
    end
    trigIn = 1'b0; trigPol = 1'b0; cyc(4);

    // R10: flag clear with and without a simultaneous set
    curReq = "R10";
    trigMode = 2'd1; prescSel = 2'd2; cmpMode = 2'd0;
    flagClr = 1'b1; cyc(10); flagClr = 1'b0; cyc(3);
    flagClr = 1'b1; cyc(1); flagClr = 1'b0; cyc(6);
    top = 16'd0; count = 16'd9; cyc(4);
    flagClr = 1'b1; cyc(1); flagClr = 1'b0; cyc(4);
    trigMode = 2'd0; cyc(2);

    // R11: gating in several modes and both polarities
    curReq = "R11";
    gateEn = 1'b1;
    for (int pol = 0; pol < 2; pol++) begin
      trigPol = pol[0];
      for (int md = 0; md < 3; md++) begin
        trigMode = 2'(md);
        for (int k = 0; k < 4; k++) begin trigIn = ~trigIn; cyc(k + 2); end
      end
    end
    gateEn = 1'b0; trigIn = ~trigIn; cyc(4);
    trigMode = 2'd0; cyc(2);

    chkOn = 1'b0;
    summary();
    $finish;
  end
endmodule